// File: doc/BRIEF.md
# Posted-Pending Interrupt Controller

This block gathers interrupt requests from a set of sources for a small 8-bit processor. Each source first records its request in a posted latch on the rising edge of its request line. A per-source mask bit decides whether a posted request moves on into a pending latch. While a request is masked it stays posted, and it becomes pending one clock after software unmasks it.

A fixed-priority encoder picks the lowest-numbered pending source. Software reads that source's vector byte through a vector register on a synchronous 8-bit register bus, and a read of 00h means that nothing is pending. Any write to the vector register drops every pending request at once. A single-cycle acknowledge from the processor removes only the entry the vector register would report. The interrupt line to the processor is high while anything is pending and the global enable input is high. A one-bit software-interrupt enable register is also held here for use by the rest of the system.

Top module: `irq_ctrl`

## Requirements
- R1: After reset all mask bits are 0, the software-interrupt enable bit is 0, no request is posted or pending, `irq_o` is 0 and `rdata_o` is 00h.
- R2: A rising edge on `req_i[i]` sets source i's posted latch at the next clock edge, whatever its mask bit. A posted request stays latched while masked and becomes pending one clock edge after its mask bit reads 1. The posted latch clears as it moves.
- R3: Mask bit value 0 blocks a source from becoming pending and value 1 allows it. Mask byte k is read/write at address k, and its bit j belongs to source 8k+j. Bits for sources that do not exist read 0.
- R4: A read at address 0xF returns, one cycle after the read strobe, the vector byte (i+1)*4 of the lowest-numbered pending source i. Source 0 has the highest priority.
- R5: A vector read with nothing pending returns 00h.
- R6: A write to address 0xF, with any data, clears every pending request.
- R7: A posted request that moves to pending in the same cycle as a clear-all write is kept pending.
- R8: A one-cycle pulse on `ack_i` removes only the highest-priority pending request. The others stay pending.
- R9: `irq_o` is 1 exactly when some request is pending and `glob_en_i` is 1.
- R10: Address 0xE holds the software-interrupt enable in bit 0. It is read/write and drives `swint_en_o`, and its bits 7..1 read 0.
- R11: A request line held high posts only once. Without a new rising edge it does not post again after its pending entry is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | N_SRC | Source request lines, rising edge posts |
| glob_en_i | input | 1 | Global interrupt enable from the processor |
| ack_i | input | 1 | Single-cycle service acknowledge |
| addr_i | input | ADDR_W | Register address |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, valid the cycle after `rd_i`, 00h otherwise |
| irq_o | output | 1 | Interrupt request to the processor |
| swint_en_o | output | 1 | Software-interrupt enable bit |

## Verification
A request edge shows up as posted after one clock edge and as pending (and on `irq_o`) after a second edge when it is unmasked. Read data and the effects of a clear-all write or an acknowledge land at the first edge after the strobe, and `irq_o` follows `glob_en_i` within the same cycle. The bench steps a requirement model in lockstep with each clock edge: it computes the next state from the inputs driven before that edge and compares outputs one time unit after the edge. So every expectation is sampled in the cycle its result is due. Directed sequences line up the coincident cases, for example a move into pending in the same cycle as a clear-all write, and then check literal vector values.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int unsigned VEC_STEP = 4;

  function automatic logic [7:0] vec_of(input int idx);
    return 8'((idx + 1) * VEC_STEP);
  endfunction
endpackage

// File: rtl/irq_src_cell.sv
module irq_src_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic mask_i,
  input  logic clr_all_i,
  input  logic ack_sel_i,
  output logic posted_o,
  output logic pending_o
);
  logic req_q, post_q, pend_q;
  logic rise, move;

  assign rise = req_i & ~req_q;
  assign move = post_q & mask_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q  <= 1'b0;
      post_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      req_q  <= req_i;
      post_q <= rise | (post_q & ~mask_i);
      // move wins over clear-all and ack
      pend_q <= move | (pend_q & ~clr_all_i & ~ack_sel_i);
    end
  end

  assign posted_o  = post_q;
  assign pending_o = pend_q;
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int unsigned N_SRC = 12
) (
  input  logic [N_SRC-1:0] pend_i,
  output logic [N_SRC-1:0] sel_oh_o,
  output logic [7:0]       vec_o
);
  import irq_pkg::*;

  always_comb begin
    sel_oh_o = '0;
    vec_o    = 8'h00;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (pend_i[i]) begin
        sel_oh_o    = '0;
        sel_oh_o[i] = 1'b1;
        vec_o       = vec_of(i);
      end
    end
  end
endmodule

// File: rtl/irq_regbus.sv
module irq_regbus #(
  parameter int unsigned N_SRC  = 12,
  parameter int unsigned ADDR_W = 4,
  parameter logic [ADDR_W-1:0] A_SWEN = 'hE,
  parameter logic [ADDR_W-1:0] A_VEC  = 'hF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [7:0]        wdata_i,
  input  logic [7:0]        vec_i,
  output logic [N_SRC-1:0]  mask_o,
  output logic              swen_o,
  output logic              clr_all_o,
  output logic [7:0]        rdata_o
);
  logic [N_SRC-1:0] mask_q;
  logic             swen_q;
  logic [7:0]       rdata_q, rd_val;

  assign clr_all_o = wr_i && (addr_i == A_VEC);

  always_comb begin
    rd_val = 8'h00;
    if (addr_i == A_SWEN) rd_val = {7'b0, swen_q};
    if (addr_i == A_VEC)  rd_val = vec_i;
    for (int b = 0; b < int'(N_SRC); b++) begin
      if (addr_i == ADDR_W'(b / 8)) rd_val[b % 8] = mask_q[b];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q  <= '0;
      swen_q  <= 1'b0;
      rdata_q <= 8'h00;
    end else begin
      if (wr_i) begin
        for (int b = 0; b < int'(N_SRC); b++) begin
          if (addr_i == ADDR_W'(b / 8)) mask_q[b] <= wdata_i[b % 8];
        end
        if (addr_i == A_SWEN) swen_q <= wdata_i[0];
      end
      rdata_q <= rd_i ? rd_val : 8'h00;
    end
  end

  assign mask_o  = mask_q;
  assign swen_o  = swen_q;
  assign rdata_o = rdata_q;
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl #(
  parameter int unsigned N_SRC  = 12,
  parameter int unsigned ADDR_W = 4,
  parameter logic [ADDR_W-1:0] A_SWEN = 'hE,
  parameter logic [ADDR_W-1:0] A_VEC  = 'hF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_SRC-1:0]  req_i,
  input  logic              glob_en_i,
  input  logic              ack_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  output logic              irq_o,
  output logic              swint_en_o
);
  localparam int unsigned N_MASK_REGS = (N_SRC + 7) / 8;

  initial begin
    if (N_SRC < 1 || N_SRC > 63) $error("N_SRC must be 1..63 so vectors fit a byte");
    if (N_MASK_REGS > int'(A_SWEN)) $error("mask bytes overlap control addresses");
  end

  logic [N_SRC-1:0] mask_w, post_w, pend_w, sel_oh_w;
  logic [7:0]       vec_w;
  logic             clr_all_w;

  irq_regbus #(
    .N_SRC(N_SRC), .ADDR_W(ADDR_W), .A_SWEN(A_SWEN), .A_VEC(A_VEC)
  ) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .addr_i   (addr_i),
    .rd_i     (rd_i),
    .wr_i     (wr_i),
    .wdata_i  (wdata_i),
    .vec_i    (vec_w),
    .mask_o   (mask_w),
    .swen_o   (swint_en_o),
    .clr_all_o(clr_all_w),
    .rdata_o  (rdata_o)
  );

  for (genvar i = 0; i < int'(N_SRC); i++) begin : g_src
    irq_src_cell u_cell (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .req_i    (req_i[i]),
      .mask_i   (mask_w[i]),
      .clr_all_i(clr_all_w),
      .ack_sel_i(ack_i & sel_oh_w[i]),
      .posted_o (post_w[i]),
      .pending_o(pend_w[i])
    );
  end

  irq_prio_enc #(.N_SRC(N_SRC)) u_enc (
    .pend_i  (pend_w),
    .sel_oh_o(sel_oh_w),
    .vec_o   (vec_w)
  );

  assign irq_o = glob_en_i & (|pend_w);
endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk #(
  parameter int unsigned N_SRC  = 12,
  parameter int unsigned ADDR_W = 4,
  parameter logic [ADDR_W-1:0] A_VEC = 'hF
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              glob_en_i,
  input logic              ack_i,
  input logic              rd_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [7:0]        rdata_o,
  input logic              irq_o,
  input logic [N_SRC-1:0]  mask_w,
  input logic [N_SRC-1:0]  post_w,
  input logic [N_SRC-1:0]  pend_w,
  input logic              clr_all_w
);
  // R2: a masked posted request is not lost
  a_r2_posted_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (($past(post_w) & ~$past(mask_w) & ~post_w) == '0));

  // R3: pending bits only appear where the mask allowed them
  a_r3_mask_gates: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((pend_w & ~$past(pend_w) & ~$past(mask_w)) == '0));

  // R5: empty vector read returns zero
  a_r5_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == A_VEC && pend_w == '0) |=> (rdata_o == 8'h00));

  // R6: clear-all leaves only requests moving in that cycle
  a_r6_clear_all: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_all_w |=> ((pend_w & ~$past(post_w & mask_w)) == '0));

  // R8: an acknowledge drops at most one pending entry
  a_r8_ack_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !clr_all_w) |=> $onehot0($past(pend_w) & ~pend_w));

  // R9: no interrupt without enable or pending
  a_r9_irq_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (glob_en_i && pend_w != '0));
endmodule

bind irq_ctrl irq_ctrl_chk #(.N_SRC(N_SRC), .ADDR_W(ADDR_W), .A_VEC(A_VEC)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .glob_en_i(glob_en_i),
  .ack_i    (ack_i),
  .rd_i     (rd_i),
  .addr_i   (addr_i),
  .rdata_o  (rdata_o),
  .irq_o    (irq_o),
  .mask_w   (mask_w),
  .post_w   (post_w),
  .pend_w   (pend_w),
  .clr_all_w(clr_all_w)
);

// File: tb/sim_irq_ctrl.sv
module sim_irq_ctrl;
  localparam int N = 12;
  localparam int CLK_PERIOD = 10;
  localparam logic [3:0] A_SWEN = 4'hE;
  localparam logic [3:0] A_VEC  = 4'hF;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic [N-1:0] req_i = '0;
  logic         glob_en_i = 1'b1;
  logic         ack_i = 1'b0;
  logic [3:0]   addr_i = '0;
  logic         rd_i = 1'b0;
  logic         wr_i = 1'b0;
  logic [7:0]   wdata_i = '0;
  logic [7:0]   rdata_o;
  logic         irq_o, swint_en_o;

  irq_ctrl #(.N_SRC(N)) u0 (.*);

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [N-1:0] m_reqp, m_post, m_pend, m_mask;
  logic         m_swen;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] m_vec(input logic [N-1:0] p);
    for (int i = 0; i < N; i++) if (p[i]) return 8'((i + 1) * 4);
    return 8'h00;
  endfunction

  function automatic logic [7:0] m_read(input logic [3:0] a);
    logic [7:0] v = 8'h00;
    if (a == A_VEC) v = m_vec(m_pend);
    else if (a == A_SWEN) v = {7'b0, m_swen};
    else for (int b = 0; b < N; b++) if (a == 4'(b / 8)) v[b % 8] = m_mask[b];
    return v;
  endfunction

  // one clock edge; model stepped from the inputs driven before it
  task automatic cycle();
    logic [N-1:0] rise, move, ackm, pn, po, mn;
    logic [7:0] erd;
    logic sn;
    string tag;
    bit clr;
    rise = req_i & ~m_reqp;
    move = m_post & m_mask;
    ackm = '0;
    if (ack_i) for (int i = N - 1; i >= 0; i--) if (m_pend[i]) begin ackm = '0; ackm[i] = 1'b1; end
    clr = wr_i && addr_i == A_VEC;
    pn = (m_pend & ~(clr ? {N{1'b1}} : {N{1'b0}}) & ~ackm) | move;
    po = rise | (m_post & ~m_mask);
    erd = rd_i ? m_read(addr_i) : 8'h00;
    tag = !rd_i ? "R4" : (addr_i == A_VEC) ? ((m_pend == '0) ? "R5" : "R4") :
          (addr_i == A_SWEN) ? "R10" : "R3";
    mn = m_mask; sn = m_swen;
    if (wr_i) begin
      for (int b = 0; b < N; b++) if (addr_i == 4'(b / 8)) mn[b] = wdata_i[b % 8];
      if (addr_i == A_SWEN) sn = wdata_i[0];
    end
    @(posedge clk_i); #1;
    m_reqp = req_i; m_post = po; m_pend = pn; m_mask = mn; m_swen = sn;
    check(rdata_o == erd, tag, rdata_o, erd);
    check(irq_o == ((|m_pend) & glob_en_i), "R9", irq_o, (|m_pend) & glob_en_i);
    check(swint_en_o == m_swen, "R10", swint_en_o, m_swen);
  endtask

  task automatic wr_reg(input logic [3:0] a, input logic [7:0] d);
    addr_i = a; wdata_i = d; wr_i = 1'b1; cycle(); wr_i = 1'b0;
  endtask

  task automatic rd_chk(input logic [3:0] a, input logic [7:0] exp, input string tag);
    addr_i = a; rd_i = 1'b1; cycle(); rd_i = 1'b0;
    check(rdata_o == exp, tag, rdata_o, exp);
  endtask

  task automatic ack_pulse();
    ack_i = 1'b1; cycle(); ack_i = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    m_reqp = '0; m_post = '0; m_pend = '0; m_mask = '0; m_swen = 1'b0;
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    // R1 reset state
    check(irq_o == 1'b0, "R1", irq_o, 0);
    check(rdata_o == 8'h00, "R1", rdata_o, 0);
    check(swint_en_o == 1'b0, "R1", swint_en_o, 0);
    rd_chk(4'h0, 8'h00, "R1");
    rd_chk(4'h1, 8'h00, "R1");
    rd_chk(A_SWEN, 8'h00, "R1");
    rd_chk(A_VEC, 8'h00, "R5");

    // R2/R3: masked request stays posted, then pends once unmasked
    req_i[3] = 1'b1;
    repeat (3) cycle();
    rd_chk(A_VEC, 8'h00, "R3");
    check(irq_o == 1'b0, "R3", irq_o, 0);
    wr_reg(4'h0, 8'h08);
    cycle();
    rd_chk(A_VEC, 8'h10, "R2");
    rd_chk(4'h1, 8'h00, "R3");

    // R6/R11: clear-all with arbitrary data; held line does not re-post
    wr_reg(A_VEC, 8'hA5);
    repeat (3) cycle();
    rd_chk(A_VEC, 8'h00, "R6");
    rd_chk(A_VEC, 8'h00, "R11");
    req_i[3] = 1'b0;

    // R3 upper mask byte, unused bits read 0
    wr_reg(4'h0, 8'hFF);
    wr_reg(4'h1, 8'hFF);
    rd_chk(4'h1, 8'h0F, "R3");

    // R4/R8: priority and single-entry acknowledge
    req_i[5] = 1'b1; req_i[9] = 1'b1;
    cycle();
    req_i[5] = 1'b0; req_i[9] = 1'b0;
    cycle(); cycle();
    rd_chk(A_VEC, 8'h18, "R4");
    ack_pulse();
    rd_chk(A_VEC, 8'h28, "R8");
    ack_pulse();
    rd_chk(A_VEC, 8'h00, "R8");

    // R7: move into pending coincides with clear-all
    req_i[7] = 1'b1;
    repeat (3) cycle();
    req_i[2] = 1'b1;
    cycle();
    wr_reg(A_VEC, 8'h00);
    rd_chk(A_VEC, 8'h0C, "R7");
    ack_pulse();
    rd_chk(A_VEC, 8'h00, "R6");
    req_i = '0;

    // R9: enable gating; R4 source 0 vector
    req_i[0] = 1'b1;
    cycle(); cycle();
    req_i[0] = 1'b0;
    glob_en_i = 1'b0; #1;
    check(irq_o == 1'b0, "R9", irq_o, 0);
    glob_en_i = 1'b1; #1;
    check(irq_o == 1'b1, "R9", irq_o, 1);
    rd_chk(A_VEC, 8'h04, "R4");
    wr_reg(A_VEC, 8'h00);

    // R10
    wr_reg(A_SWEN, 8'hFF);
    rd_chk(A_SWEN, 8'h01, "R10");
    check(swint_en_o == 1'b1, "R10", swint_en_o, 1);
    wr_reg(A_SWEN, 8'h00);
    rd_chk(A_SWEN, 8'h00, "R10");

    // random phase checked by the model every cycle
    for (int k = 0; k < 4000; k++) begin
      int op;
      if ($urandom % 3 == 0) req_i[$urandom % N] ^= 1'b1;
      glob_en_i = ($urandom % 8) != 0;
      op = $urandom % 12;
      case (op)
        0: wr_reg(4'($urandom % 2), 8'($urandom));
        1: if ($urandom % 4 == 0) wr_reg(A_VEC, 8'($urandom)); else cycle();
        2, 3: begin
          addr_i = (op == 2) ? A_VEC : 4'($urandom % 16);
          rd_i = 1'b1; cycle(); rd_i = 1'b0;
        end
        4: ack_pulse();
        5: wr_reg(A_SWEN, 8'($urandom));
        default: cycle();
      endcase
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule